// File: doc/BRIEF.md
# Secure OTP Region Program Filter

This block guards byte writes into a 1024-byte one-time-programmable secure area. The area is divided into 32 regions of 32 bytes. Region 0 is special. Its lowest sixteen bytes hold a factory entropy value. Four bytes at offsets 0x10 to 0x13 hold one lock bit per region. The rest of region 0 is reserved. Regions 1 to 31 start blank (0xFF), and user data is normally written from address 0x20 upward.

Each request carries a byte address, a data byte and a strobe. The filter reads the lock bits held in the array and makes one of three decisions for the request:
- **Program:** the write goes ahead. The stored byte becomes the old byte ANDed with the data, so bits can only move from erased (1) to programmed (0).
- **Reject:** the target region is locked.
- **Ignore:** the write falls inside region 0 but outside the lock bytes.

The array is modelled as a plain byte memory with a second, combinational read port for inspection.

Top module: `otp_program_filter`

## Requirements
- R1: After reset, `prog_en`, `rejected` and `ignored` are 0. Every byte outside region-0 offsets 0x00–0x0F reads 0xFF on `rd_data`.
- R2: The region index is `req_addr[9:5]` and the byte offset within the region is `req_addr[4:0]`.
- R3: A request to an unlocked region 1–31 raises `prog_en` for one cycle, in the cycle after the strobe. `prog_addr` equals the request address, and the same value appears at that address on `rd_data` from then on.
- R4: The programmed value is the old byte AND the data byte. A later write can never turn a 0 bit back into 1.
- R5: The lock bit for region n is bit n%8 of the byte at offset 0x10 + n/8 of region 0. A value of 0 means locked and 1 means open. A request to a locked region pulses `rejected` for one cycle and leaves the array unchanged.
- R6: While region 0 is open, a request to region-0 offsets 0x00–0x0F or 0x14–0x1F pulses `ignored` and leaves the array unchanged.
- R7: Region-0 offsets 0x10–0x13 are programmable while region 0 is open. Once bit 0 of offset 0x10 is 0, writes to those bytes are rejected, and rejection takes precedence over ignore.
- R8: After reset, byte i of region 0 (i = 0..15) reads (0xA5 + 29·i) mod 256, and no request changes it.
- R9: At most one of `prog_en`, `rejected` and `ignored` is high in any cycle, and none is high in a cycle that follows a cycle without a strobe.
- R10: Every strobe gets its decision one cycle later. Requests on consecutive cycles each see the array as left by the request before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, also reloads the array model |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | 10 | Byte address of the request |
| req_data | input | 8 | Data byte of the request |
| rd_addr | input | 10 | Inspection read address |
| rd_data | output | 8 | Combinational read of the array at `rd_addr` |
| prog_en | output | 1 | One-cycle pulse: the request was programmed |
| prog_addr | output | 10 | Address that was programmed |
| prog_data | output | 8 | Effective byte written (old AND data) |
| rejected | output | 1 | One-cycle pulse: the request hit a locked region |
| ignored | output | 1 | One-cycle pulse: the request hit a non-lock byte of region 0 |

## Verification
The bench builds the block with its default parameters: a 10-bit address, 8-bit bytes, 32-byte regions, lock bytes at offset 0x10 and the entropy seed 0xA5 with step 29. These values put all four lock bytes in reach. They let locking region 1, region 8 and region 31 be exercised from different lock bytes and bit positions. They also allow region 0 to lock itself, which freezes its own lock bytes. The entropy formula gives fixed values that the bench recomputes for all sixteen entropy bytes.

// File: rtl/otp_filter_pkg.sv
package otp_filter_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE    = 2'd0,
      VERDICT_PROGRAM = 2'd1,
      VERDICT_REJECT  = 2'd2,
      VERDICT_IGNORE  = 2'd3
   } verdict_e;

   // Decision order: lock check wins over the region-0 window check.
   function automatic verdict_e pick_verdict(input logic strobe,
                                             input logic locked,
                                             input logic is_region0,
                                             input logic in_lock_window);
      verdict_e v;
      if (!strobe)                          v = VERDICT_NONE;
      else if (locked)                      v = VERDICT_REJECT;
      else if (is_region0 && !in_lock_window) v = VERDICT_IGNORE;
      else                                  v = VERDICT_PROGRAM;
      return v;
   endfunction

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode #(
   parameter int ADDR_W      = 10,
   parameter int REGION_LOG2 = 5,
   parameter int LOCK_OFFSET = 16,
   parameter int LOCK_BYTES  = 4
) (
   input  logic [ADDR_W-1:0]             addr,
   output logic [ADDR_W-REGION_LOG2-1:0] region,
   output logic                          is_region0,
   output logic                          in_lock_window
);
   localparam int REGION_W = ADDR_W - REGION_LOG2;
   localparam logic [REGION_LOG2-1:0] WIN_LO = REGION_LOG2'(LOCK_OFFSET);
   localparam logic [REGION_LOG2-1:0] WIN_HI = REGION_LOG2'(LOCK_OFFSET + LOCK_BYTES - 1);

   logic [REGION_LOG2-1:0] offset;

   assign region         = addr[ADDR_W-1:REGION_LOG2];
   assign offset         = addr[REGION_LOG2-1:0];
   assign is_region0     = (region == REGION_W'(0));
   assign in_lock_window = (offset >= WIN_LO) && (offset <= WIN_HI);
endmodule

// File: rtl/otp_lock_vector.sv
module otp_lock_vector #(
   parameter int   DATA_W      = 8,
   parameter int   LOCK_BYTES  = 4,
   parameter int   REGION_W    = 5,
   parameter logic LOCK_LEVEL  = 1'b0
) (
   input  logic [LOCK_BYTES*DATA_W-1:0] lock_flat,
   input  logic [REGION_W-1:0]          region,
   output logic                         region_locked
);
   localparam int NUM_REGIONS = LOCK_BYTES * DATA_W;

   logic [NUM_REGIONS-1:0] locked_vec;

   // Region n maps to byte n/DATA_W, bit n%DATA_W of the flat lock field.
   for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_lock
      assign locked_vec[n] = (lock_flat[n] == LOCK_LEVEL);
   end

   assign region_locked = locked_vec[region];
endmodule

// File: rtl/otp_byte_array.sv
module otp_byte_array #(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter int ENTROPY_LEN  = 16,
   parameter int ENTROPY_SEED = 165,
   parameter int ENTROPY_STEP = 29,
   parameter int LOCK_OFFSET  = 16,
   parameter int LOCK_BYTES   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rda_addr,
   output logic [DATA_W-1:0]            rda_data,
   input  logic [ADDR_W-1:0]            rdb_addr,
   output logic [DATA_W-1:0]            rdb_data,
   output logic [LOCK_BYTES*DATA_W-1:0] lock_flat
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= (i < ENTROPY_LEN) ? DATA_W'(ENTROPY_SEED + ENTROPY_STEP * i) : '1;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rda_data = mem[rda_addr];
   assign rdb_data = mem[rdb_addr];

   for (genvar k = 0; k < LOCK_BYTES; k++) begin : g_lock_tap
      assign lock_flat[k*DATA_W +: DATA_W] = mem[LOCK_OFFSET + k];
   end
endmodule

// File: rtl/otp_program_filter.sv
module otp_program_filter #(
   parameter int   ADDR_W       = 10,
   parameter int   DATA_W       = 8,
   parameter int   REGION_LOG2  = 5,
   parameter int   ENTROPY_LEN  = 16,
   parameter int   LOCK_OFFSET  = 16,
   parameter int   ENTROPY_SEED = 165,
   parameter int   ENTROPY_STEP = 29,
   parameter logic LOCK_LEVEL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              prog_en,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              rejected,
   output logic              ignored
);
   import otp_filter_pkg::*;

   localparam int REGION_W     = ADDR_W - REGION_LOG2;
   localparam int REGION_BYTES = 1 << REGION_LOG2;
   localparam int NUM_REGIONS  = 1 << REGION_W;
   localparam int LOCK_BYTES   = NUM_REGIONS / DATA_W;

   if (NUM_REGIONS % DATA_W != 0) begin : g_bad_lock_pack
      $error("region count must fill whole lock bytes");
   end
   if (LOCK_OFFSET + LOCK_BYTES > REGION_BYTES) begin : g_bad_lock_fit
      $error("lock bytes must fit inside region 0");
   end
   if (ENTROPY_LEN > LOCK_OFFSET) begin : g_bad_entropy
      $error("entropy bytes must sit below the lock bytes");
   end

   logic [REGION_W-1:0]          req_region;
   logic                         req_is_r0;
   logic                         req_in_win;
   logic                         req_locked;
   logic [LOCK_BYTES*DATA_W-1:0] lock_flat;
   logic [DATA_W-1:0]            old_byte;
   logic [DATA_W-1:0]            merged;
   logic                         do_write;
   verdict_e                     verdict;

   otp_addr_decode #(
      .ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2),
      .LOCK_OFFSET(LOCK_OFFSET), .LOCK_BYTES(LOCK_BYTES)
   ) u_decode (
      .addr(req_addr), .region(req_region),
      .is_region0(req_is_r0), .in_lock_window(req_in_win)
   );

   otp_lock_vector #(
      .DATA_W(DATA_W), .LOCK_BYTES(LOCK_BYTES),
      .REGION_W(REGION_W), .LOCK_LEVEL(LOCK_LEVEL)
   ) u_locks (
      .lock_flat(lock_flat), .region(req_region), .region_locked(req_locked)
   );

   otp_byte_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTROPY_LEN(ENTROPY_LEN),
      .ENTROPY_SEED(ENTROPY_SEED), .ENTROPY_STEP(ENTROPY_STEP),
      .LOCK_OFFSET(LOCK_OFFSET), .LOCK_BYTES(LOCK_BYTES)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(do_write), .wr_addr(req_addr), .wr_data(merged),
      .rda_addr(req_addr), .rda_data(old_byte),
      .rdb_addr(rd_addr), .rdb_data(rd_data),
      .lock_flat(lock_flat)
   );

   always_comb begin
      verdict  = pick_verdict(req_valid, req_locked, req_is_r0, req_in_win);
      merged   = old_byte & req_data;
      do_write = (verdict == VERDICT_PROGRAM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_en   <= 1'b0;
         rejected  <= 1'b0;
         ignored   <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         prog_en  <= (verdict == VERDICT_PROGRAM);
         rejected <= (verdict == VERDICT_REJECT);
         ignored  <= (verdict == VERDICT_IGNORE);
         if (verdict == VERDICT_PROGRAM) begin
            prog_addr <= req_addr;
            prog_data <= merged;
         end
      end
   end
endmodule

// File: rtl/otp_program_filter_chk.sv
module otp_program_filter_chk #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int REGION_LOG2 = 5,
   parameter int LOCK_OFFSET = 16,
   parameter int LOCK_BYTES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic              prog_en,
   input logic [ADDR_W-1:0] prog_addr,
   input logic [DATA_W-1:0] prog_data,
   input logic              rejected,
   input logic              ignored
);
   localparam int REGION_W = ADDR_W - REGION_LOG2;

   logic [ADDR_W-1:0] last_addr;
   logic [DATA_W-1:0] last_data;
   logic [REGION_LOG2-1:0] last_off;
   logic [REGION_LOG2-1:0] prog_off;
   logic last_in_win;
   logic prog_in_win;

   always_ff @(posedge clk) begin
      last_addr <= req_addr;
      last_data <= req_data;
   end

   assign last_off    = last_addr[REGION_LOG2-1:0];
   assign prog_off    = prog_addr[REGION_LOG2-1:0];
   assign last_in_win = (int'(last_off) >= LOCK_OFFSET) && (int'(last_off) < LOCK_OFFSET + LOCK_BYTES);
   assign prog_in_win = (int'(prog_off) >= LOCK_OFFSET) && (int'(prog_off) < LOCK_OFFSET + LOCK_BYTES);

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_en, rejected, ignored}));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(prog_en || rejected || ignored));

   assert_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (prog_en || rejected || ignored));

   assert_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid ##1 prog_en |-> prog_addr == last_addr);

   assert_onetime_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid ##1 prog_en |-> (prog_data & ~last_data) == '0);

   assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid ##1 ignored |-> (last_addr[ADDR_W-1:REGION_LOG2] == REGION_W'(0)) && !last_in_win);

   assert_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && prog_addr[ADDR_W-1:REGION_LOG2] == REGION_W'(0)) |-> prog_in_win);
endmodule

bind otp_program_filter otp_program_filter_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_LOG2(REGION_LOG2),
   .LOCK_OFFSET(LOCK_OFFSET), .LOCK_BYTES(LOCK_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_data(req_data), .prog_en(prog_en), .prog_addr(prog_addr),
   .prog_data(prog_data), .rejected(rejected), .ignored(ignored)
);

// File: tb/otp_program_filter_bench.sv
module otp_program_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [9:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic [9:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       prog_en;
   logic [9:0] prog_addr;
   logic [7:0] prog_data;
   logic       rejected;
   logic       ignored;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   otp_program_filter u_otp_program_filter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .rejected(rejected), .ignored(ignored)
   );

   // {addr[9:0], data[7:0], kind[1:0] (0 program, 1 reject, 2 ignore), byte after[7:0]}
   localparam int NVEC = 19;
   localparam logic [27:0] VEC [NVEC] = '{
      {10'h020, 8'hF0, 2'd0, 8'hF0},  // R3 first user byte
      {10'h020, 8'h3C, 2'd0, 8'h30},  // R4 AND merge
      {10'h3FF, 8'h00, 2'd0, 8'h00},  // R2 last byte, region 31
      {10'h005, 8'h00, 2'd2, 8'h36},  // R6 entropy byte ignored
      {10'h01A, 8'h00, 2'd2, 8'hFF},  // R6 reserved byte ignored
      {10'h010, 8'hFD, 2'd0, 8'hFD},  // R7 lock region 1
      {10'h021, 8'h00, 2'd1, 8'hFF},  // R5 region 1 locked
      {10'h020, 8'h00, 2'd1, 8'h30},  // R5 locked data kept
      {10'h013, 8'h7F, 2'd0, 8'h7F},  // R7 lock region 31
      {10'h3FE, 8'h00, 2'd1, 8'hFF},  // R5 region 31 locked
      {10'h040, 8'hA5, 2'd0, 8'hA5},  // R3 region 2 open
      {10'h011, 8'hFE, 2'd0, 8'hFE},  // R7 lock region 8
      {10'h100, 8'h00, 2'd1, 8'hFF},  // R5 region 8 locked
      {10'h0E0, 8'h0F, 2'd0, 8'h0F},  // R2 region 7 open
      {10'h010, 8'hFF, 2'd0, 8'hFD},  // R4 no bit returns to 1
      {10'h010, 8'hFE, 2'd0, 8'hFC},  // R7 region 0 locks itself
      {10'h012, 8'h00, 2'd1, 8'hFF},  // R7 lock bytes frozen
      {10'h00F, 8'h00, 2'd1, 8'h58},  // R7 reject beats ignore
      {10'h040, 8'h0F, 2'd0, 8'h05}   // R4 region 2 still open
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] entropy(input int i);
      return 8'((165 + 29 * i) % 256);
   endfunction

   task automatic read_check(input string req, input logic [9:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      check(req, {24'd0, rd_data}, {24'd0, exp});
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 prog_en", {31'd0, prog_en}, 32'd0);
      check("R1 rejected", {31'd0, rejected}, 32'd0);
      check("R1 ignored", {31'd0, ignored}, 32'd0);
      read_check("R1 user byte", 10'h020, 8'hFF);
      read_check("R1 lock byte", 10'h010, 8'hFF);
      read_check("R1 reserved", 10'h01F, 8'hFF);
      read_check("R1 last byte", 10'h3FF, 8'hFF);
      // R8 entropy bytes
      for (int i = 0; i < 16; i++) read_check("R8 entropy", 10'(i), entropy(i));

      // R9 idle cycles produce nothing
      @(negedge clk);
      check("R9 idle", {29'd0, prog_en, rejected, ignored}, 32'd0);

      // Vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [9:0] a;
         logic [7:0] d;
         logic [1:0] k;
         logic [7:0] e;
         {a, d, k, e} = VEC[v];
         req_addr  = a;
         req_data  = d;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check($sformatf("R9 R10 verdict vec %0d", v), {29'd0, prog_en, rejected, ignored},
               {29'd0, (k == 2'd0), (k == 2'd1), (k == 2'd2)});
         if (k == 2'd0) begin
            check($sformatf("R3 prog_addr vec %0d", v), {22'd0, prog_addr}, {22'd0, a});
            check($sformatf("R4 prog_data vec %0d", v), {24'd0, prog_data}, {24'd0, e});
         end
         read_check($sformatf("R5 R6 byte vec %0d", v), a, e);
         @(negedge clk);
         check($sformatf("R9 pulse ends vec %0d", v), {29'd0, prog_en, rejected, ignored}, 32'd0);
      end

      // R10 back-to-back requests to region 3
      req_addr = 10'h060; req_data = 8'hF0; req_valid = 1'b1;
      @(negedge clk);
      check("R10 first prog", {31'd0, prog_en}, 32'd1);
      check("R10 first data", {24'd0, prog_data}, 32'h0F0);
      req_data = 8'h0F;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 second prog", {31'd0, prog_en}, 32'd1);
      check("R10 second data", {24'd0, prog_data}, 32'h000);
      read_check("R10 stored", 10'h060, 8'h00);

      // R8 entropy untouched after all requests
      read_check("R8 entropy kept", 10'h005, entropy(5));
      read_check("R8 entropy kept", 10'h00F, entropy(15));

      // R1 reset restores blank model
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_check("R1 after reset", 10'h020, 8'hFF);
      read_check("R1 lock after reset", 10'h010, 8'hFF);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule